// File: doc/BRIEF.md
# Patrol and Demand Memory Scrubber

This block sits inside a memory controller and keeps stored data free of accumulating soft errors. Every word in memory carries SECDED protection: 32 data bits, 6 Hamming check bits and one overall parity bit. On its own, with no software involvement once an interval is programmed, the engine walks the populated address window one word at a time. It reads each word, checks it and, when exactly one bit is wrong, writes the corrected codeword back before a second upset can make it unrecoverable.

A second source of work comes from the normal read path. When a regular read had to be corrected in flight, the controller raises a demand request with that address, and the engine rewrites the location with clean data. Demand work always goes ahead of a pending patrol step, and the patrol resumes where it left off. The engine reaches memory through a request/grant port shared with normal traffic. It keeps its request raised from the read of a step until the step is over, so that no other access can slip between its read and its write-back. Corrected and uncorrectable outcomes are reported as one-cycle pulses, in saturating counters and in an address register.

Top module: `scrub_engine`

## Requirements
- R1: A stored codeword holds data in bits [31:0], check bits in [37:32] and overall parity in bit 38. The data bits are assigned in ascending order to Hamming positions 1..38, skipping the powers of two. Check bit j is the XOR of the positions of all set data bits, taken at bit j. Bit 38 is the XOR of bits [37:0]. Every write-back carries exactly this encoding of the corrected data.
- R2: Patrol reads visit only addresses in the inclusive window cfgBase..cfgLimit. They go in ascending order and wrap from cfgLimit back to cfgBase, so words outside the window are never read or repaired by the patrol.
- R3: When cfgInterval is N > 0, at least N cycles with memReq low separate the end of one step from the next patrol read. When cfgInterval is 0, no patrol read is issued.
- R4: A word with exactly one flipped bit, in any of the 39 positions, is rewritten at the same address in the same step, and evtCorr pulses for one cycle.
- R5: A word with two flipped bits pulses evtUncorr, and no write is issued for it, so memory keeps the damaged word.
- R6: A clean word causes no write and no event.
- R7: A demand request (dmdValid with dmdAddr) is accepted with dmdReady while the engine is idle. It performs the same read, check and rewrite at dmdAddr, inside or outside the patrol window.
- R8: A demand request that arrives while a patrol step is due is served first, with dmdReady high in that same cycle. The following patrol read uses the address the patrol would have used next.
- R9: memReq stays high from an accepted read until the read data returns and, if a write-back follows, until that write is granted.
- R10: corrCount and uncorrCount count evtCorr and evtUncorr pulses and hold at their all-ones value instead of wrapping.
- R11: lastErrAddr holds the address of the most recent step that produced either event.
- R12: While rstN is low, memReq, both event outputs, both counters and lastErrAddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgInterval | input | INTV_W | Idle cycles before each patrol read; 0 stops the patrol |
| cfgBase | input | ADDR_W | Lowest populated address |
| cfgLimit | input | ADDR_W | Highest populated address |
| dmdValid | input | 1 | Demand rewrite request |
| dmdAddr | input | ADDR_W | Address to rewrite on demand |
| dmdReady | output | 1 | Demand request taken this cycle |
| memReq | output | 1 | Memory port requested; held through a whole step |
| memCmd | output | 1 | A command is presented this cycle |
| memWe | output | 1 | Presented command is a write |
| memAddr | output | ADDR_W | Command address |
| memWdata | output | 39 | Corrected codeword to write |
| memGnt | input | 1 | Port granted; a command is taken when memCmd and memGnt are both high |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 39 | Read codeword |
| evtCorr | output | 1 | One-cycle pulse: single-bit error repaired |
| evtUncorr | output | 1 | One-cycle pulse: uncorrectable error seen |
| corrCount | output | CNT_W | Saturating count of corrected events |
| uncorrCount | output | CNT_W | Saturating count of uncorrectable events |
| lastErrAddr | output | ADDR_W | Address of the latest error event |

## Verification
The hardest situation to reach is a demand request landing in the very cycle a patrol step becomes due, because the interval timer normally sets that cycle. The bench first leaves the patrol disabled long enough for the idle timer to run past one. In a single cycle it then sets the interval to one and raises a demand. Both sources are now pending together, and the bench checks the order and addresses of the next two reads. The single-bit case is swept over all 39 codeword positions through demand rewrites, and the memory model's grant stalls check that the request stays held across a whole step.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DATA_W  = 32;
  localparam int CHK_W   = 6;
  localparam int WORD_W  = DATA_W + CHK_W + 1;
  localparam int MAX_POS = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    ECC_CLEAN = 2'd0,
    ECC_FIXED = 2'd1,
    ECC_FATAL = 2'd2
  } eccClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startPatrol;
    logic startDemand;
    logic capture;
    logic finish;
  } scrubCtl_t;

  // Hamming position of data bit idx (non-power-of-two slots, ascending)
  function automatic int slotOf(input int idx);
    int k;
    int p;
    k = 0;
    p = 0;
    for (int q = 1; q <= MAX_POS; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (k == idx) p = q;
        k++;
      end
    end
    return p;
  endfunction

  function automatic logic [CHK_W-1:0] checkBits(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int j = 0; j < CHK_W; j++)
      for (int i = 0; i < DATA_W; i++)
        if (((slotOf(i) >> j) & 1) == 1) c[j] = c[j] ^ d[i];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] encodeWord(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = checkBits(d);
    return {^{c, d}, c, d};
  endfunction
endpackage

// File: rtl/scrub_secded.sv
module scrub_secded
  import scrub_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output eccClass_t         cls,
  output logic [DATA_W-1:0] data
);
  logic [CHK_W-1:0]  syn;
  logic              parOdd;
  logic              synPow2;
  logic              synHit;
  logic [DATA_W-1:0] flip;

  always_comb begin
    syn     = checkBits(word[DATA_W-1:0]) ^ word[DATA_W+CHK_W-1:DATA_W];
    parOdd  = ^word;
    synPow2 = (syn & (syn - 1'b1)) == '0;
    flip    = '0;
    synHit  = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (int'(syn) == slotOf(i)) begin
        flip[i] = 1'b1;
        synHit  = 1'b1;
      end
    end
    data = word[DATA_W-1:0] ^ flip;
    if (!parOdd)
      cls = (syn == '0) ? ECC_CLEAN : ECC_FATAL;
    else if (synPow2 || synHit)
      cls = ECC_FIXED;
    else
      cls = ECC_FATAL;
  end
endmodule

// File: rtl/scrub_dpath.sv
module scrub_dpath
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INTV_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  scrubCtl_t         ctl,
  input  logic              busy,
  input  logic [INTV_W-1:0] cfgInterval,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic [ADDR_W-1:0] dmdAddr,
  input  logic [WORD_W-1:0] memRdata,
  output logic              decFixable,
  output logic              patrolDue,
  output logic [ADDR_W-1:0] stepAddr,
  output logic              stepIsPatrol,
  output logic [WORD_W-1:0] wrWord,
  output logic              evtCorr,
  output logic              evtUncorr,
  output logic [CNT_W-1:0]  corrCount,
  output logic [CNT_W-1:0]  uncorrCount,
  output logic [ADDR_W-1:0] lastErrAddr
);
  localparam logic [INTV_W-1:0] INTV_MAX = '1;
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam int NUM_EVT = 2;

  eccClass_t         decCls;
  logic [DATA_W-1:0] decData;
  logic [ADDR_W-1:0] ptr;
  logic [INTV_W-1:0] waitCnt;
  logic              ptrInRange;
  logic [NUM_EVT-1:0] evtHit;
  logic [NUM_EVT-1:0] evtPulse;
  logic [CNT_W-1:0]   evtCnt [NUM_EVT];

  scrub_secded u_dec (
    .word (memRdata),
    .cls  (decCls),
    .data (decData)
  );

  assign decFixable = (decCls == ECC_FIXED);
  assign ptrInRange = (ptr >= cfgBase) && (ptr <= cfgLimit);
  assign patrolDue  = (cfgInterval != '0) && (waitCnt >= cfgInterval);

  // idle-time spacing between patrol reads
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              waitCnt <= '0;
    else if (ctl.startPatrol)               waitCnt <= '0;
    else if (!busy && waitCnt != INTV_MAX)  waitCnt <= waitCnt + 1'b1;
  end

  // step address and patrol pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr          <= '0;
      stepAddr     <= '0;
      stepIsPatrol <= 1'b0;
    end else begin
      if (ctl.startPatrol) begin
        stepAddr     <= ptrInRange ? ptr : cfgBase;
        stepIsPatrol <= 1'b1;
      end else if (ctl.startDemand) begin
        stepAddr     <= dmdAddr;
        stepIsPatrol <= 1'b0;
      end
      if (ctl.finish && stepIsPatrol)
        ptr <= (stepAddr >= cfgLimit) ? cfgBase : stepAddr + 1'b1;
    end
  end

  // corrected codeword and error address
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrWord      <= '0;
      lastErrAddr <= '0;
    end else if (ctl.capture) begin
      wrWord <= encodeWord(decData);
      if (decCls != ECC_CLEAN) lastErrAddr <= stepAddr;
    end
  end

  assign evtHit[0] = ctl.capture && (decCls == ECC_FIXED);
  assign evtHit[1] = ctl.capture && (decCls == ECC_FATAL);

  // one pulse and one saturating counter per event kind
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        evtPulse[g] <= 1'b0;
        evtCnt[g]   <= '0;
      end else begin
        evtPulse[g] <= evtHit[g];
        if (evtHit[g] && evtCnt[g] != CNT_MAX) evtCnt[g] <= evtCnt[g] + 1'b1;
      end
    end
  end

  assign evtCorr     = evtPulse[0];
  assign evtUncorr   = evtPulse[1];
  assign corrCount   = evtCnt[0];
  assign uncorrCount = evtCnt[1];
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dmdValid,
  input  logic      patrolDue,
  input  logic      memGnt,
  input  logic      memRvalid,
  input  logic      decFixable,
  output scrubCtl_t ctl,
  output logic      busy,
  output logic      dmdReady,
  output logic      memReq,
  output logic      memCmd,
  output logic      memWe
);
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_WRITE = 2'd3
  } scrubState_t;

  scrubState_t state;
  scrubState_t stateNext;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (dmdValid) begin
          ctl.startDemand = 1'b1;
          stateNext       = ST_READ;
        end else if (patrolDue) begin
          ctl.startPatrol = 1'b1;
          stateNext       = ST_READ;
        end
      end
      ST_READ: if (memGnt) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (memRvalid) begin
          ctl.capture = 1'b1;
          if (decFixable) stateNext = ST_WRITE;
          else begin
            ctl.finish = 1'b1;
            stateNext  = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (memGnt) begin
          ctl.finish = 1'b1;
          stateNext  = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign dmdReady = (state == ST_IDLE) && dmdValid;
  assign memReq   = (state != ST_IDLE);
  assign busy     = memReq;
  assign memCmd   = (state == ST_READ) || (state == ST_WRITE);
  assign memWe    = (state == ST_WRITE);
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int INTV_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INTV_W-1:0] cfgInterval,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [ADDR_W-1:0] cfgLimit,
  input  logic              dmdValid,
  input  logic [ADDR_W-1:0] dmdAddr,
  output logic              dmdReady,
  output logic              memReq,
  output logic              memCmd,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [WORD_W-1:0] memRdata,
  output logic              evtCorr,
  output logic              evtUncorr,
  output logic [CNT_W-1:0]  corrCount,
  output logic [CNT_W-1:0]  uncorrCount,
  output logic [ADDR_W-1:0] lastErrAddr
);
  scrubCtl_t ctl;
  logic      busy;
  logic      patrolDue;
  logic      decFixable;
  logic      stepIsPatrol;

  scrub_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .dmdValid   (dmdValid),
    .patrolDue  (patrolDue),
    .memGnt     (memGnt),
    .memRvalid  (memRvalid),
    .decFixable (decFixable),
    .ctl        (ctl),
    .busy       (busy),
    .dmdReady   (dmdReady),
    .memReq     (memReq),
    .memCmd     (memCmd),
    .memWe      (memWe)
  );

  scrub_dpath #(
    .ADDR_W (ADDR_W),
    .INTV_W (INTV_W),
    .CNT_W  (CNT_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .busy         (busy),
    .cfgInterval  (cfgInterval),
    .cfgBase      (cfgBase),
    .cfgLimit     (cfgLimit),
    .dmdAddr      (dmdAddr),
    .memRdata     (memRdata),
    .decFixable   (decFixable),
    .patrolDue    (patrolDue),
    .stepAddr     (memAddr),
    .stepIsPatrol (stepIsPatrol),
    .wrWord       (memWdata),
    .evtCorr      (evtCorr),
    .evtUncorr    (evtUncorr),
    .corrCount    (corrCount),
    .uncorrCount  (uncorrCount),
    .lastErrAddr  (lastErrAddr)
  );
endmodule

// File: rtl/scrub_engine_chk.sv
module scrub_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int INTV_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [INTV_W-1:0] cfgInterval,
  input logic [ADDR_W-1:0] cfgBase,
  input logic [ADDR_W-1:0] cfgLimit,
  input logic              dmdValid,
  input logic              dmdReady,
  input logic              memReq,
  input logic              memCmd,
  input logic              memWe,
  input logic              memGnt,
  input logic [ADDR_W-1:0] memAddr,
  input logic              stepIsPatrol,
  input logic              evtCorr,
  input logic              evtUncorr,
  input logic [CNT_W-1:0]  corrCount,
  input logic [CNT_W-1:0]  uncorrCount
);
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd && memGnt && !memWe) |=> memReq); // R9

  AST_NO_FATAL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    evtUncorr |-> !(memCmd && memWe)); // R5

  AST_FIX_WRITES: assert property (@(posedge clk) disable iff (!rstN)
    evtCorr |-> (memReq && memCmd && memWe)); // R4

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evtCorr, evtUncorr})); // R4

  AST_PATROL_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd && stepIsPatrol) |-> (memAddr >= cfgBase && memAddr <= cfgLimit)); // R2

  AST_PATROL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cfgInterval == '0 && !memReq && !dmdValid) |=> !memReq); // R3

  AST_DEMAND_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (dmdValid && !memReq) |-> dmdReady); // R8

  AST_CORR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    corrCount >= $past(corrCount)); // R10

  AST_UNCORR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    uncorrCount >= $past(uncorrCount)); // R10
endmodule

bind scrub_engine scrub_engine_chk #(
  .ADDR_W (ADDR_W),
  .INTV_W (INTV_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgInterval  (cfgInterval),
  .cfgBase      (cfgBase),
  .cfgLimit     (cfgLimit),
  .dmdValid     (dmdValid),
  .dmdReady     (dmdReady),
  .memReq       (memReq),
  .memCmd       (memCmd),
  .memWe        (memWe),
  .memGnt       (memGnt),
  .memAddr      (memAddr),
  .stepIsPatrol (stepIsPatrol),
  .evtCorr      (evtCorr),
  .evtUncorr    (evtUncorr),
  .corrCount    (corrCount),
  .uncorrCount  (uncorrCount)
);

// File: tb/scrub_engine_test.sv
`timescale 1ns/1ps
module scrub_engine_test;
  localparam int AW = 4;
  localparam int IW = 8;
  localparam int CW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] cfgInterval = '0;
  logic [AW-1:0] cfgBase = 4'd2;
  logic [AW-1:0] cfgLimit = 4'd11;
  logic          dmdValid = 1'b0;
  logic [AW-1:0] dmdAddr = '0;
  logic          dmdReady, memReq, memCmd, memWe;
  logic [AW-1:0] memAddr;
  logic [38:0]   memWdata;
  logic          memGnt;
  logic          memRvalid = 1'b0;
  logic [38:0]   memRdata = '0;
  logic          evtCorr, evtUncorr;
  logic [CW-1:0] corrCount, uncorrCount;
  logic [AW-1:0] lastErrAddr;

  always #10 clk = ~clk;

  scrub_engine #(.ADDR_W(AW), .INTV_W(IW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .cfgInterval(cfgInterval), .cfgBase(cfgBase),
    .cfgLimit(cfgLimit), .dmdValid(dmdValid), .dmdAddr(dmdAddr),
    .dmdReady(dmdReady), .memReq(memReq), .memCmd(memCmd), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt),
    .memRvalid(memRvalid), .memRdata(memRdata), .evtCorr(evtCorr),
    .evtUncorr(evtUncorr), .corrCount(corrCount), .uncorrCount(uncorrCount),
    .lastErrAddr(lastErrAddr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // memory model, arbiter with normal-traffic stalls
  logic [38:0]   mem [DEPTH];
  logic [7:0]    lfsr = 8'h5b;
  logic          lockHeld = 1'b0;
  logic          pendRd = 1'b0;
  int            rdCnt = 0;
  int            wrCnt = 0;
  logic [AW-1:0] rdLog [128];

  assign memGnt = memReq && (lockHeld || !(lfsr[0] & lfsr[3]));

  always @(posedge clk) begin
    lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    lockHeld  <= memReq && memGnt;
    memRvalid <= 1'b0;
    if (memRvalid) pendRd <= 1'b0;
    if (memReq && memGnt && memCmd) begin
      if (memWe) begin
        mem[memAddr] <= memWdata;
        wrCnt <= wrCnt + 1;
      end else begin
        memRvalid <= 1'b1;
        memRdata  <= mem[memAddr];
        pendRd    <= 1'b1;
        rdLog[rdCnt % 128] <= memAddr;
        rdCnt <= rdCnt + 1;
      end
    end
  end

  // monitors
  int  lowRun = 1000;
  bit  prevReq = 1'b0;
  bit  gapEn = 1'b0;
  int  gapMin = 0;
  int  gapBad = 0;
  int  holdBad = 0;
  int  corrPulses = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (pendRd && !memReq) holdBad++;
      if (evtCorr) corrPulses++;
      if (!memReq) lowRun++;
      else if (!prevReq) begin
        if (gapEn && lowRun < gapMin) gapBad++;
        lowRun = 0;
      end
      prevReq = memReq;
    end
  end

  function automatic logic [38:0] benchEnc(input logic [31:0] d);
    logic [38:0] w;
    logic [5:0]  c;
    int          k;
    c = '0;
    k = 0;
    for (int pos = 1; pos <= 38; pos++) begin
      if ((pos & (pos - 1)) != 0) begin
        if (d[k]) c = c ^ 6'(pos);
        k++;
      end
    end
    w = {1'b0, c, d};
    w[38] = ^w[37:0];
    return w;
  endfunction

  function automatic logic [31:0] dataOf(input int i);
    return 32'h1234_5678 ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic doDemand(input logic [AW-1:0] a);
    @(negedge clk);
    dmdAddr  = a;
    dmdValid = 1'b1;
    #1;
    while (!dmdReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    dmdValid = 1'b0;
    while (memReq) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    int r0;
    int w0;
    logic [38:0] bad;
    logic [31:0] d;
    for (int i = 0; i < DEPTH; i++) mem[i] = benchEnc(dataOf(i));
    mem[3]  = mem[3]  ^ (39'd1 << 10);
    mem[5]  = mem[5]  ^ (39'd1 << 34);
    mem[7]  = mem[7]  ^ (39'd1 << 38);
    mem[9]  = mem[9]  ^ ((39'd1 << 4) | (39'd1 << 20));
    mem[0]  = mem[0]  ^ (39'd1 << 1);
    mem[13] = mem[13] ^ (39'd1 << 30);

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 memReq", 64'(memReq), 64'd0);
    chk("R12 events", 64'({evtCorr, evtUncorr}), 64'd0);
    chk("R12 corrCount", 64'(corrCount), 64'd0);
    chk("R12 uncorrCount", 64'(uncorrCount), 64'd0);
    chk("R12 lastErrAddr", 64'(lastErrAddr), 64'd0);
    rstN = 1'b1;

    // patrol sweep over window 2..11 with interval 3
    gapMin = 3;
    gapEn = 1'b1;
    cfgInterval = 8'd3;
    while (rdCnt < 10) @(negedge clk);
    cfgInterval = '0;
    repeat (12) @(negedge clk);
    gapEn = 1'b0;
    for (int i = 0; i < 10; i++) chk("R2 patrol order", 64'(rdLog[i]), 64'(i + 2));
    chk("R3 gap between patrol reads", 64'(gapBad), 64'd0);
    chk("R4 data-bit repair", mem[3], benchEnc(dataOf(3)));
    chk("R4 check-bit repair", mem[5], benchEnc(dataOf(5)));
    chk("R4 parity-bit repair", mem[7], benchEnc(dataOf(7)));
    chk("R5 double error kept", mem[9],
        benchEnc(dataOf(9)) ^ ((39'd1 << 4) | (39'd1 << 20)));
    chk("R2 below window untouched", mem[0], benchEnc(dataOf(0)) ^ (39'd1 << 1));
    chk("R2 above window untouched", mem[13], benchEnc(dataOf(13)) ^ (39'd1 << 30));
    chk("R6 writes only for single errors", 64'(wrCnt), 64'd3);
    chk("R10 corrCount after sweep", 64'(corrCount), 64'd3);
    chk("R10 uncorrCount after sweep", 64'(uncorrCount), 64'd1);
    chk("R11 lastErrAddr after sweep", 64'(lastErrAddr), 64'd9);
    chk("R4 corr pulses", 64'(corrPulses), 64'd3);

    // interval 0 stops the patrol
    r0 = rdCnt;
    repeat (40) @(negedge clk);
    chk("R3 no patrol at interval 0", 64'(rdCnt), 64'(r0));

    // demand rewrites outside the window, and a clean demand
    doDemand(4'd13);
    chk("R7 demand repair 13", mem[13], benchEnc(dataOf(13)));
    doDemand(4'd0);
    chk("R7 demand repair 0", mem[0], benchEnc(dataOf(0)));
    chk("R11 lastErrAddr after demand", 64'(lastErrAddr), 64'd0);
    chk("R10 corrCount after demands", 64'(corrCount), 64'd5);
    w0 = wrCnt;
    doDemand(4'd4);
    chk("R6 clean demand no write", 64'(wrCnt), 64'(w0));
    chk("R6 clean demand no count", 64'(corrCount), 64'd5);

    // demand and due patrol in the same cycle
    r0 = rdCnt;
    @(negedge clk);
    cfgInterval = 8'd1;
    dmdAddr = 4'd14;
    dmdValid = 1'b1;
    #1;
    chk("R8 demand taken while patrol due", 64'(dmdReady), 64'd1);
    @(negedge clk);
    dmdValid = 1'b0;
    while (rdCnt < r0 + 2) @(negedge clk);
    cfgInterval = '0;
    while (memReq) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R8 demand read first", 64'(rdLog[r0 % 128]), 64'd14);
    chk("R8 patrol resumes at base", 64'(rdLog[(r0 + 1) % 128]), 64'd2);

    // uncorrectable demand
    bad = benchEnc(dataOf(15)) ^ ((39'd1 << 0) | (39'd1 << 33));
    mem[15] = bad;
    w0 = wrCnt;
    doDemand(4'd15);
    chk("R5 no write on double error", 64'(wrCnt), 64'(w0));
    chk("R5 word unchanged", mem[15], bad);
    chk("R5 uncorrCount", 64'(uncorrCount), 64'd2);
    chk("R11 lastErrAddr 15", 64'(lastErrAddr), 64'd15);

    // every single-bit position
    w0 = corrPulses;
    for (int b = 0; b < 39; b++) begin
      d = dataOf(100 + b);
      mem[15] = benchEnc(d) ^ (39'd1 << b);
      doDemand(4'd15);
      chk($sformatf("R4 R1 bit %0d repaired", b), mem[15], benchEnc(d));
    end
    chk("R4 pulse per repair", 64'(corrPulses - w0), 64'd39);
    chk("R10 corrCount saturates", 64'(corrCount), 64'd7);

    for (int n = 0; n < 6; n++) begin
      mem[15] = bad;
      doDemand(4'd15);
    end
    chk("R10 uncorrCount saturates", 64'(uncorrCount), 64'd7);
    chk("R9 request held through step", 64'(holdBad), 64'd0);
    finish();
  end
endmodule